// File: doc/BRIEF.md
# Status-Polling Bus Master

This block is a small bus master for a pipelined, handshake-per-beat memory bus with a stall signal. It runs a fixed routine against one status location in a single peripheral. First it reads the status once to learn its initial value. Then, for a set number of rounds, it does three things in order: it stays off the bus for a fixed number of cycles, it writes zero to the status location to start an operation, and it reads the status again and again until the value returned is zero. When the last round ends it raises a completion flag.

Each access is a single beat. The request is held while the slave stalls. The strobe is withdrawn once the request is taken, and the cycle line stays up until the acknowledge arrives. The routine exposes the last value read and a count of how many times the polled value changed. A watchdog ends any access whose acknowledge does not come in time, and flags the failure.

Top module: `poll_master`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `bus_cyc`, `bus_stb`, `seq_done` and `wdog_err` low and `change_cnt` at zero.
- R2: Every access starts with `bus_cyc` and `bus_stb` rising in the same cycle. In that cycle `bus_we` is valid, `bus_addr` equals `STATUS_ADDR` and `bus_wdata` is zero. `bus_stb` is never high without `bus_cyc`.
- R3: While `bus_stb` and `bus_stall` are both high, the next cycle keeps `bus_stb`, `bus_cyc` and `bus_we` unchanged.
- R4: In the cycle after a request is taken (`bus_stb` high, `bus_stall` low), `bus_stb` is low and `bus_cyc` is still high.
- R5: An `bus_ack` seen while `bus_cyc` is high and `bus_stb` is low ends the access, so `bus_cyc` is low in the next cycle. For a read, `last_value` then holds the `bus_rdata` of the acknowledge cycle.
- R6: `start`, sampled while the master is idle or finished, launches a read and clears `seq_done`, `wdog_err` and `change_cnt`. At the start of each round there are exactly `IDLE_WAIT` (default 5) cycles with `bus_cyc` low, followed by a write (`bus_we`=1) of zero.
- R7: After the write is acknowledged, and after each poll read that returns a nonzero value, there is exactly one cycle with `bus_cyc` low and then a read. A poll that returns zero ends the round.
- R8: After `ROUNDS` (default 2) rounds, `seq_done` is high and no further access starts until the next `start`. A full run therefore makes 1 + `ROUNDS`×(polls per round) reads and `ROUNDS` writes.
- R9: `change_cnt` goes up by one for each poll read whose value differs from the previous value read (the first poll of a run is compared with the initial read). It does not change at any other time except when it is cleared.
- R10: If no acknowledge arrives within `WDOG` (default 64) cycles after the request is taken, `bus_cyc` drops, `wdog_err` rises, and the master goes idle with `seq_done` low. An acknowledge that arrives after this is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch the routine (idle or finished only) |
| bus_cyc | output | 1 | Bus cycle active |
| bus_stb | output | 1 | Request strobe |
| bus_we | output | 1 | Write enable |
| bus_addr | output | AW | Address, always `STATUS_ADDR` |
| bus_wdata | output | DW | Write data, always zero |
| bus_stall | input | 1 | Slave cannot take the request this cycle |
| bus_ack | input | 1 | Slave acknowledge |
| bus_rdata | input | DW | Read data, valid with `bus_ack` |
| seq_done | output | 1 | All rounds complete |
| wdog_err | output | 1 | An access was aborted by the watchdog |
| last_value | output | DW | Last value read |
| change_cnt | output | CW | Number of polled-value changes |

## Verification
The in-line assertions check the bus handshake on every cycle. They cover the strobe only appearing inside a cycle, the request being held under stall, the strobe withdrawn after acceptance, the cycle closed after the acknowledge, the change count moving only on acknowledges, and the state after reset and after a watchdog abort. The bench's scenarios cover what needs a whole run to see. They check the exact idle gaps before the start write and between polls, the number of reads and writes, the change count for various status sequences, stall depths and acknowledge latencies, and the watchdog limit: an acknowledge at latency 64 is accepted and one at latency 65 is aborted.

// File: rtl/poll_master.sv
module poll_master #(
  parameter int AW          = 8,
  parameter int DW          = 32,
  parameter int CW          = 8,
  parameter int IDLE_WAIT   = 5,
  parameter int ROUNDS      = 2,
  parameter int WDOG        = 64,
  parameter int STATUS_ADDR = 0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          bus_cyc,
  output logic          bus_stb,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_wdata,
  input  logic          bus_stall,
  input  logic          bus_ack,
  input  logic [DW-1:0] bus_rdata,
  output logic          seq_done,
  output logic          wdog_err,
  output logic [DW-1:0] last_value,
  output logic [CW-1:0] change_cnt
);
  localparam int WCW = $clog2(WDOG + 1);
  localparam int IW  = $clog2(IDLE_WAIT + 1);
  localparam int RW  = $clog2(ROUNDS + 1);

  typedef enum logic [2:0] {S_IDLE, S_INIT, S_WAIT, S_TRIG, S_GAP, S_POLL, S_DONE} st_t;

  st_t          st;
  logic [WCW-1:0] wcnt;
  logic [IW-1:0]  icnt;
  logic [RW-1:0]  rnd;

  logic taken, fin, tmo;
  assign taken = bus_stb && !bus_stall;
  assign fin   = bus_cyc && !bus_stb && bus_ack;
  assign tmo   = bus_cyc && !bus_stb && !bus_ack && (wcnt == WCW'(WDOG - 1));

  assign bus_addr  = AW'(STATUS_ADDR);
  assign bus_wdata = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      st         <= S_IDLE;
      bus_cyc    <= 1'b0;
      bus_stb    <= 1'b0;
      bus_we     <= 1'b0;
      wcnt       <= '0;
      icnt       <= '0;
      rnd        <= '0;
      seq_done   <= 1'b0;
      wdog_err   <= 1'b0;
      last_value <= '0;
      change_cnt <= '0;
    end else begin
      if (taken) begin
        bus_stb <= 1'b0;
        wcnt    <= '0;
      end else if (bus_cyc && !bus_stb) begin
        wcnt <= wcnt + 1'b1;
      end
      if (fin) bus_cyc <= 1'b0;

      case (st)
        S_IDLE, S_DONE: if (start) begin
          bus_cyc    <= 1'b1;
          bus_stb    <= 1'b1;
          bus_we     <= 1'b0;
          seq_done   <= 1'b0;
          wdog_err   <= 1'b0;
          change_cnt <= '0;
          rnd        <= '0;
          st         <= S_INIT;
        end
        S_INIT: if (fin) begin
          last_value <= bus_rdata;
          icnt       <= '0;
          st         <= S_WAIT;
        end
        S_WAIT: begin
          if (icnt == IW'(IDLE_WAIT - 1)) begin
            bus_cyc <= 1'b1;
            bus_stb <= 1'b1;
            bus_we  <= 1'b1;
            st      <= S_TRIG;
          end else begin
            icnt <= icnt + 1'b1;
          end
        end
        S_TRIG: if (fin) st <= S_GAP;
        S_GAP: begin
          bus_cyc <= 1'b1;
          bus_stb <= 1'b1;
          bus_we  <= 1'b0;
          st      <= S_POLL;
        end
        S_POLL: if (fin) begin
          last_value <= bus_rdata;
          if (bus_rdata != last_value) change_cnt <= change_cnt + 1'b1;
          if (bus_rdata != '0) begin
            st <= S_GAP;
          end else if (rnd == RW'(ROUNDS - 1)) begin
            seq_done <= 1'b1;
            st       <= S_DONE;
          end else begin
            rnd  <= rnd + 1'b1;
            icnt <= '0;
            st   <= S_WAIT;
          end
        end
        default: st <= S_IDLE;
      endcase

      if (tmo) begin
        bus_cyc  <= 1'b0;
        wdog_err <= 1'b1;
        st       <= S_IDLE;
      end
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> !bus_cyc && !bus_stb && !seq_done && !wdog_err && change_cnt == '0);

  assert_stb_in_cyc_R2: assert property (@(posedge clk) disable iff (rst)
    bus_stb |-> bus_cyc);

  assert_hold_under_stall_R3: assert property (@(posedge clk) disable iff (rst)
    bus_stb && bus_stall |=> bus_stb && bus_cyc && $stable(bus_we));

  assert_stb_drop_R4: assert property (@(posedge clk) disable iff (rst)
    bus_stb && !bus_stall |=> !bus_stb && bus_cyc);

  assert_ack_closes_R5: assert property (@(posedge clk) disable iff (rst)
    bus_cyc && !bus_stb && bus_ack |=> !bus_cyc);

  assert_done_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    seq_done |-> !bus_cyc && !wdog_err);

  assert_count_on_ack_R9: assert property (@(posedge clk) disable iff (rst)
    !(bus_cyc && !bus_stb && bus_ack) && !start |=> $stable(change_cnt));

  assert_abort_drops_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(wdog_err) |-> !bus_cyc && !seq_done);
endmodule

// File: tb/tb_poll_master.sv
module tb_poll_master;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8, DW = 32, CW = 8;
  localparam int IDLE_WAIT = 5, ROUNDS = 2, WDOG = 64;
  // columns: initial status, start value K, stall cycles, ack latency, expected changes
  localparam int VEC [0:3][0:4] = '{
    '{3, 4, 0, 1, 10},
    '{0, 0, 1, 2, 0},
    '{5, 5, 2, 3, 11},
    '{7, 2, 0, 64, 6}
  };

  logic clk = 0, rst = 1, start = 0;
  logic bus_cyc, bus_stb, bus_we, bus_stall, bus_ack, seq_done, wdog_err;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata, last_value;
  logic [CW-1:0] change_cnt;

  int checks = 0, fails = 0, cycles = 0;

  poll_master #(.AW(AW), .DW(DW), .CW(CW), .IDLE_WAIT(IDLE_WAIT), .ROUNDS(ROUNDS), .WDOG(WDOG))
    dut (.clk(clk), .rst(rst), .start(start), .bus_cyc(bus_cyc), .bus_stb(bus_stb),
         .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_stall(bus_stall),
         .bus_ack(bus_ack), .bus_rdata(bus_rdata), .seq_done(seq_done), .wdog_err(wdog_err),
         .last_value(last_value), .change_cnt(change_cnt));

  always #(CLK_PERIOD/2) clk = ~clk;

  // slave model
  int cfg_init = 0, cfg_k = 0, cfg_stall = 0, cfg_lat = 1;
  int stl_cnt, ack_cnt, cur;
  logic run;
  logic [DW-1:0] rd_q;
  assign bus_stall = bus_stb && (stl_cnt < cfg_stall);
  assign bus_ack   = (ack_cnt == 1);
  assign bus_rdata = rd_q;

  always @(posedge clk) begin
    if (rst) begin
      stl_cnt <= 0; ack_cnt <= 0; cur <= 0; run <= 0; rd_q <= '0;
    end else begin
      if (start) begin cur <= cfg_init; run <= 0; end
      if (bus_stb && bus_stall) stl_cnt <= stl_cnt + 1;
      if (ack_cnt != 0) ack_cnt <= ack_cnt - 1;
      if (bus_cyc && bus_stb && !bus_stall) begin
        stl_cnt <= 0;
        ack_cnt <= cfg_lat;
        if (bus_we) begin cur <= cfg_k; run <= 1; end
        else begin
          rd_q <= DW'(cur);
          if (run && cur != 0) cur <= cur - 1;
        end
      end
    end
  end

  // bus monitor, sampled at the falling edge
  int reads, writes, hold_bad, acc_bad, ack_bad, gap_bad, idle_cnt, wait_cnt;
  logic first, p_cyc, p_stb, p_we, p_stall, p_ack;
  logic [DW-1:0] p_rdata;
  always @(negedge clk) begin
    if (rst || start) begin
      reads = 0; writes = 0; hold_bad = 0; acc_bad = 0; ack_bad = 0; gap_bad = 0;
      idle_cnt = 0; wait_cnt = 0; first = 1;
    end else begin
      if (p_stb && p_stall && !(bus_stb && bus_cyc && bus_we == p_we)) hold_bad++;
      if (p_stb && !p_stall && !(bus_cyc && !bus_stb)) acc_bad++;
      if (p_cyc && !p_stb && p_ack) begin
        if (bus_cyc) ack_bad++;
        if (!p_we && last_value != p_rdata) ack_bad++;
      end
      if (bus_cyc && !p_cyc) begin
        wait_cnt = 0;
        if (!bus_stb || bus_addr != AW'(0) || bus_wdata != '0) acc_bad++;
        if (bus_we) begin
          writes++;
          if (idle_cnt != IDLE_WAIT) gap_bad++;
        end else begin
          reads++;
          if (!first && idle_cnt != 1) gap_bad++;
        end
        first = 0;
      end
      if (bus_cyc && !bus_stb) wait_cnt++;
      idle_cnt = bus_cyc ? 0 : idle_cnt + 1;
    end
    p_cyc = bus_cyc; p_stb = bus_stb; p_we = bus_we; p_stall = bus_stall;
    p_ack = bus_ack; p_rdata = bus_rdata;
  end

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_start();
    @(posedge clk); #1 start = 1;
    @(posedge clk); #1 start = 0;
    @(negedge clk);
    chk("R2", "cyc and stb rise together", {bus_cyc, bus_stb}, 2'b11);
    chk("R6", "first access is a read, flags cleared", {bus_we, seq_done, wdog_err}, 3'b000);
    chk("R6", "change count cleared", change_cnt, 0);
  endtask

  task automatic wait_end();
    for (int n = 0; n < 20000 && !seq_done && !wdog_err; n++) @(negedge clk);
  endtask

  task automatic run_vec(int init, int k, int stl, int lat, int exp_chg);
    cfg_init = init; cfg_k = k; cfg_stall = stl; cfg_lat = lat;
    pulse_start();
    wait_end();
    chk("R8", "done after all rounds", {seq_done, wdog_err, bus_cyc}, 3'b100);
    chk("R9", "change count", change_cnt, exp_chg);
    chk("R5", "last value is final zero", last_value, 0);
    chk("R8", "read count", reads, 1 + ROUNDS * (k + 1));
    chk("R6", "write count", writes, ROUNDS);
    chk("R3", "request held under stall", hold_bad, 0);
    chk("R4", "strobe dropped after acceptance", acc_bad, 0);
    chk("R5", "ack closes cycle and captures data", ack_bad, 0);
    chk("R7", "idle gaps before write and polls", gap_bad, 0);
    repeat (4) @(negedge clk);
    chk("R8", "no access after done", {bus_cyc, seq_done}, 2'b01);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles >= 150000) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "reset state", {bus_cyc, bus_stb, seq_done, wdog_err}, 4'b0000);
    chk("R1", "reset change count", change_cnt, 0);
    @(posedge clk); #1 rst = 0;

    for (int i = 0; i < 4; i++)
      run_vec(VEC[i][0], VEC[i][1], VEC[i][2], VEC[i][3], VEC[i][4]);

    // watchdog: ack one cycle past the limit
    cfg_init = 1; cfg_k = 1; cfg_stall = 0; cfg_lat = WDOG + 1;
    pulse_start();
    wait_end();
    chk("R10", "error raised, cycle dropped", {wdog_err, seq_done, bus_cyc}, 3'b100);
    chk("R10", "wait cycles before abort", wait_cnt, WDOG);
    repeat (5) @(negedge clk);
    chk("R10", "late ack ignored", {bus_cyc, bus_stb, wdog_err}, 3'b001);
    chk("R10", "late ack not captured", last_value, 0);

    // recovery after abort
    run_vec(2, 3, 1, 1, 1 + 3 + 1 + 3);
    chk("R6", "error cleared by new run", wdog_err, 0);

    // reset in the middle of a run
    cfg_init = 4; cfg_k = 6; cfg_stall = 0; cfg_lat = 1;
    pulse_start();
    repeat (30) @(negedge clk);
    @(posedge clk); #1 rst = 1;
    @(posedge clk); #1 rst = 0;
    @(negedge clk);
    chk("R1", "mid-run reset state", {bus_cyc, bus_stb, seq_done, wdog_err}, 4'b0000);
    chk("R1", "mid-run reset count", change_cnt, 0);
    repeat (10) @(negedge clk);
    chk("R1", "idle after reset without start", bus_cyc, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule